// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the timing reference for a PWM generator. A 16-bit counter steps once per prescaled tick. It can count upward, downward, or up and then down, and it can also be frozen. Its limit comes from an active period register, which sits behind a shadow copy. Two single-cycle strobes mark the moments when the counter steps onto zero and onto the active period. A downstream action stage uses these strobes to set and clear waveform edges.

Configuration uses two write strobes. A control write updates the counting direction, both prescaler fields, the period-load mode and the run mode in one cycle. A period write loads a new limit. That limit either waits in the shadow register or takes effect at once, depending on the load mode. The run mode selects between free running, halting on the spot, and finishing the current cycle so that the counter parks at zero.

Top module: `pwm_timebase`

## Requirements
- R1: A synchronous active-low reset clears the counter, both period registers, the prescaler fields and both strobes. It leaves the counter in up mode with run mode 00 (halted) and the period-load bit at 0 (shadow).
- R2: The counter may advance only once every D clocks, where D = 2^divA × (divB == 0 ? 1 : 2·divB).
- R3: With mode 00 (up), the counter rises by one per tick and returns to zero on the tick after it reaches or exceeds the active period.
- R4: With mode 01 (down), the counter falls by one per tick and reloads the active period on the tick after it reaches zero.
- R5: With mode 10 (up-down), the counter rises to the active period and turns down on the next tick. At zero it turns up again.
- R6: With mode 11 (freeze), the counter holds its value.
- R7: With the load bit at 0, a period write goes only to the shadow register. The shadow value becomes the active period on the tick that steps the counter to zero.
- R8: With the load bit at 1, a period write changes the active period in the next cycle.
- R9: Run mode 00 holds the counter at its present value from the next cycle.
- R10: Run mode 01 lets the counter keep stepping while it is non-zero and holds it once it reaches zero.
- R11: zeroEvt is high for exactly the one clock that follows a tick stepping the counter to zero.
- R12: prdEvt is high for exactly the one clock that follows a tick stepping the counter to the value of the active period in force before that tick.
- Run mode 1x (10 or 11) counts freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| ctrlWe | input | 1 | Write strobe for all control fields |
| ctrlMode | input | 2 | Counting mode: 00 up, 01 down, 10 up-down, 11 freeze |
| ctrlDivA | input | 3 | Power-of-two prescaler field |
| ctrlDivB | input | 3 | Even-multiple prescaler field |
| ctrlPrdImm | input | 1 | Period load: 0 shadowed, 1 immediate |
| ctrlRun | input | 2 | Run mode: 00 halt, 01 halt at zero, 1x free |
| prdWe | input | 1 | Period write strobe |
| prdData | input | 16 | Period value to write |
| count | output | 16 | Current counter value |
| zeroEvt | output | 1 | One-clock strobe on stepping to zero |
| prdEvt | output | 1 | One-clock strobe on stepping to the period |

## Verification
The bench targets four areas.

- **Period changes mid-count.** Both the shadow and the immediate load are tested, including an immediate write below the present count. A design that copies the shadow early would move the limit mid-cycle. A design that used equality instead of reaching-or-exceeding would run up past the new limit.
- **Up-down turnarounds.** A wrong turnaround would repeat the peak or zero value, or would skip a strobe.
- **Prescaler extremes.** The divide is swept over several settings up to its maximum of 1792. An off-by-one in the divide shows up as drifting tick spacing.
- **Run modes.** Halt-at-zero is checked in both up and down directions. A design that halts early, or never halts, diverges from the reference within one period.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  typedef enum logic [1:0] {
    CNT_UP     = 2'b00,
    CNT_DOWN   = 2'b01,
    CNT_UPDOWN = 2'b10,
    CNT_FREEZE = 2'b11
  } cntMode_e;

  typedef enum logic [1:0] {
    RUN_HALT     = 2'b00,
    RUN_TO_ZERO  = 2'b01,
    RUN_FREE     = 2'b10,
    RUN_FREE_ALT = 2'b11
  } runMode_e;

  // strobes and settings passed from control to datapath
  typedef struct packed {
    logic     tick;
    cntMode_e mode;
    runMode_e run;
    logic     prdImm;
  } tbCtl_t;

endpackage

// File: rtl/pwm_tb_ctrl.sv
module pwm_tb_ctrl
  import pwm_tb_pkg::*;
#(
  parameter int DIVA_W = 3,
  parameter int DIVB_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [1:0]        ctrlMode,
  input  logic [DIVA_W-1:0] ctrlDivA,
  input  logic [DIVB_W-1:0] ctrlDivB,
  input  logic              ctrlPrdImm,
  input  logic [1:0]        ctrlRun,
  output tbCtl_t            ctl
);
  // widest divide: 2^(2^DIVA_W-1) * 2*(2^DIVB_W-1)
  localparam int PRE_W = (1 << DIVA_W) - 1 + DIVB_W + 2;

  cntMode_e          modeQ;
  runMode_e          runQ;
  logic [DIVA_W-1:0] divAQ;
  logic [DIVB_W-1:0] divBQ;
  logic              immQ;
  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  evenFactor;
  logic [PRE_W-1:0]  divFactor;
  logic [PRE_W-1:0]  divM1;
  logic              tick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= CNT_UP;
      runQ  <= RUN_HALT;
      divAQ <= '0;
      divBQ <= '0;
      immQ  <= 1'b0;
    end else if (ctrlWe) begin
      modeQ <= cntMode_e'(ctrlMode);
      runQ  <= runMode_e'(ctrlRun);
      divAQ <= ctrlDivA;
      divBQ <= ctrlDivB;
      immQ  <= ctrlPrdImm;
    end
  end

  always_comb begin
    if (divBQ == '0) evenFactor = PRE_W'(1);
    else             evenFactor = PRE_W'(divBQ) << 1;
    divFactor = evenFactor << divAQ;
    divM1     = divFactor - PRE_W'(1);
  end

  // >= so a shrinking divide never strands the counter above its limit
  assign tick = (preCnt >= divM1);

  always_ff @(posedge clk) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + PRE_W'(1);
  end

  always_comb begin
    ctl.tick   = tick;
    ctl.mode   = modeQ;
    ctl.run    = runQ;
    ctl.prdImm = immQ;
  end

endmodule

// File: rtl/pwm_tb_dpath.sv
module pwm_tb_dpath
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbCtl_t           ctl,
  input  logic             prdWe,
  input  logic [CNT_W-1:0] prdData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] prdAct,
  output logic             zeroEvt,
  output logic             prdEvt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] prdShadow;
  logic [CNT_W-1:0] nxtCnt;
  logic             dirUp;
  logic             nxtDir;
  logic             advance;
  logic             hitZero;

  always_comb begin
    advance = ctl.tick && (ctl.mode != CNT_FREEZE) &&
              (ctl.run[1] || (ctl.run == RUN_TO_ZERO && count != '0));
    nxtCnt  = count;
    nxtDir  = dirUp;
    unique case (ctl.mode)
      CNT_UP:   nxtCnt = (count >= prdAct) ? '0 : count + ONE;
      CNT_DOWN: nxtCnt = (count == '0) ? prdAct : count - ONE;
      CNT_UPDOWN: begin
        if (dirUp) begin
          if (count >= prdAct) begin
            nxtDir = 1'b0;
            nxtCnt = (count == '0) ? '0 : count - ONE;
          end else begin
            nxtCnt = count + ONE;
          end
        end else begin
          if (count == '0) begin
            nxtDir = 1'b1;
            nxtCnt = (prdAct == '0) ? '0 : ONE;
          end else begin
            nxtCnt = count - ONE;
          end
        end
      end
      default: nxtCnt = count;
    endcase
    if (ctl.mode != CNT_UPDOWN) nxtDir = 1'b1;
    hitZero = advance && (nxtCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      dirUp     <= 1'b1;
      zeroEvt   <= 1'b0;
      prdEvt    <= 1'b0;
      prdAct    <= '0;
      prdShadow <= '0;
    end else begin
      if (advance) count <= nxtCnt;
      if (advance || ctl.mode != CNT_UPDOWN) dirUp <= nxtDir;
      zeroEvt <= hitZero;
      prdEvt  <= advance && (nxtCnt == prdAct);
      if (prdWe && ctl.prdImm) prdAct <= prdData;
      else if (hitZero)        prdAct <= prdShadow;
      if (prdWe) prdShadow <= prdData;
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIVA_W = 3,
  parameter int DIVB_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [1:0]        ctrlMode,
  input  logic [DIVA_W-1:0] ctrlDivA,
  input  logic [DIVB_W-1:0] ctrlDivB,
  input  logic              ctrlPrdImm,
  input  logic [1:0]        ctrlRun,
  input  logic              prdWe,
  input  logic [CNT_W-1:0]  prdData,
  output logic [CNT_W-1:0]  count,
  output logic              zeroEvt,
  output logic              prdEvt
);
  tbCtl_t           ctlS;
  logic [CNT_W-1:0] prdAct;

  pwm_tb_ctrl #(.DIVA_W(DIVA_W), .DIVB_W(DIVB_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWe    (ctrlWe),
    .ctrlMode  (ctrlMode),
    .ctrlDivA  (ctrlDivA),
    .ctrlDivB  (ctrlDivB),
    .ctrlPrdImm(ctrlPrdImm),
    .ctrlRun   (ctrlRun),
    .ctl       (ctlS)
  );

  pwm_tb_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctlS),
    .prdWe  (prdWe),
    .prdData(prdData),
    .count  (count),
    .prdAct (prdAct),
    .zeroEvt(zeroEvt),
    .prdEvt (prdEvt)
  );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] prdAct,
  input logic             zeroEvt,
  input logic             prdEvt,
  input logic             tick,
  input logic [1:0]       cntMode,
  input logic [1:0]       runMode
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (count == '0 && !zeroEvt && !prdEvt)); // R1

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntMode == 2'b00 && runMode[1] && count < prdAct)
      |=> count == $past(count) + CNT_W'(1)); // R3

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cntMode == 2'b11) |=> count == $past(count)); // R6

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (runMode == 2'b00) |=> count == $past(count)); // R9

  AST_PARK_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (runMode == 2'b01 && count == '0) |=> count == '0); // R10

  AST_ZERO_EVT_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    zeroEvt |-> count == '0); // R11

  AST_EVT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> (!zeroEvt && !prdEvt)); // R11

  AST_PRD_EVT_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    prdEvt |-> count == $past(prdAct)); // R12

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .count  (count),
  .prdAct (prdAct),
  .zeroEvt(zeroEvt),
  .prdEvt (prdEvt),
  .tick   (ctlS.tick),
  .cntMode(ctlS.mode),
  .runMode(ctlS.run)
);

// File: tb/pwm_timebase_tb_top.sv
`timescale 1ns/1ps
module pwm_timebase_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [1:0]  ctrlMode = 2'b00;
  logic [2:0]  ctrlDivA = 3'd0;
  logic [2:0]  ctrlDivB = 3'd0;
  logic        ctrlPrdImm = 1'b0;
  logic [1:0]  ctrlRun = 2'b00;
  logic        prdWe = 1'b0;
  logic [15:0] prdData = 16'd0;
  logic [15:0] count;
  logic        zeroEvt;
  logic        prdEvt;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";
  bit done = 1'b0;

  // reference model state
  int mCnt, mPrd, mShadow, mPre, mMode, mRun, mA, mB, mImm, mDir;
  bit mZ, mP;

  always #2.5 clk = ~clk;

  pwm_timebase dut_i (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlMode(ctrlMode),
    .ctrlDivA(ctrlDivA), .ctrlDivB(ctrlDivB), .ctrlPrdImm(ctrlPrdImm),
    .ctrlRun(ctrlRun), .prdWe(prdWe), .prdData(prdData),
    .count(count), .zeroEvt(zeroEvt), .prdEvt(prdEvt)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPrd = 0; mShadow = 0; mPre = 0; mMode = 0; mRun = 0;
      mA = 0; mB = 0; mImm = 0; mDir = 1; mZ = 0; mP = 0;
    end else begin
      int div, nxt, nDir, oldShadow;
      bit tk, adv, load;
      div = (1 << mA) * ((mB == 0) ? 1 : 2 * mB);
      tk = (mPre >= div - 1);
      mPre = tk ? 0 : mPre + 1;
      adv = tk && mMode != 3 && (mRun >= 2 || (mRun == 1 && mCnt != 0));
      nxt = mCnt; nDir = mDir;
      if (mMode == 0) nxt = (mCnt >= mPrd) ? 0 : mCnt + 1;
      else if (mMode == 1) nxt = (mCnt == 0) ? mPrd : mCnt - 1;
      else if (mMode == 2) begin
        if (mDir == 1) begin
          if (mCnt >= mPrd) begin nDir = 0; nxt = (mCnt == 0) ? 0 : mCnt - 1; end
          else nxt = mCnt + 1;
        end else begin
          if (mCnt == 0) begin nDir = 1; nxt = (mPrd == 0) ? 0 : 1; end
          else nxt = mCnt - 1;
        end
      end
      mZ = adv && nxt == 0;
      mP = adv && nxt == mPrd;
      load = mZ;
      if (mMode != 2) mDir = 1;
      else if (adv) mDir = nDir;
      if (adv) mCnt = nxt;
      oldShadow = mShadow;
      if (prdWe && mImm == 1) mPrd = prdData;
      else if (load) mPrd = oldShadow;
      if (prdWe) mShadow = prdData;
      if (ctrlWe) begin
        mMode = ctrlMode; mRun = ctrlRun; mA = ctrlDivA; mB = ctrlDivB; mImm = ctrlPrdImm;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curReq, "count", int'(count), mCnt);
      check("R11", "zeroEvt", int'(zeroEvt), int'(mZ));
      check("R12", "prdEvt", int'(prdEvt), int'(mP));
    end
  end

  task automatic wrCtrl(int mode, int a, int b, int imm, int run);
    @(negedge clk);
    ctrlMode = 2'(mode); ctrlDivA = 3'(a); ctrlDivB = 3'(b);
    ctrlPrdImm = 1'(imm); ctrlRun = 2'(run); ctrlWe = 1'b1;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic wrPrd(int val);
    @(negedge clk);
    prdData = 16'(val); prdWe = 1'b1;
    @(negedge clk);
    prdWe = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "reset count", int'(count), 0);
    check("R1", "reset zeroEvt", int'(zeroEvt), 0);
    check("R1", "reset prdEvt", int'(prdEvt), 0);
    rstN = 1'b1;
    idle(5);
    check("R1", "halted after reset", int'(count), 0);

    // R3: up counting, shadow loads on first zero
    curReq = "R3";
    wrPrd(5);
    wrCtrl(0, 0, 0, 0, 2);
    idle(30);

    // R2: prescaler settings
    curReq = "R2";
    wrCtrl(0, 1, 2, 0, 2); idle(120);
    wrCtrl(0, 2, 0, 0, 2); idle(60);
    wrCtrl(0, 0, 3, 0, 3); idle(60);
    wrCtrl(0, 7, 7, 0, 2); idle(8000);
    wrCtrl(0, 0, 0, 0, 2); idle(10);

    // R4: down counting
    curReq = "R4";
    wrCtrl(1, 0, 0, 0, 2); idle(25);

    // R5: up-down counting, with divide 2
    curReq = "R5";
    wrCtrl(2, 0, 1, 0, 2); idle(60);
    wrCtrl(2, 0, 0, 0, 2); idle(30);

    // R7: shadow load mid-cycle
    curReq = "R7";
    wrCtrl(0, 0, 0, 0, 2); idle(3);
    wrPrd(9); idle(40);

    // R8: immediate load, including below the present count
    curReq = "R8";
    wrCtrl(0, 0, 0, 1, 2); idle(7);
    wrPrd(3); idle(20);
    wrPrd(12); idle(30);
    wrCtrl(2, 0, 0, 1, 2); idle(9);
    wrPrd(4); idle(25);

    // R6: freeze
    curReq = "R6";
    wrCtrl(0, 0, 0, 1, 2); idle(5);
    wrCtrl(3, 0, 0, 1, 2); idle(12);

    // R9: halt on the spot
    curReq = "R9";
    wrCtrl(0, 0, 0, 1, 2); idle(6);
    wrCtrl(0, 0, 0, 1, 0); idle(12);

    // R10: halt at zero, in up and down
    curReq = "R10";
    wrCtrl(0, 0, 0, 1, 2); idle(4);
    wrCtrl(0, 0, 0, 1, 1); idle(30);
    check("R10", "parked at zero (up)", int'(count), 0);
    wrCtrl(1, 0, 0, 1, 2); idle(5);
    wrCtrl(1, 0, 0, 1, 1); idle(30);
    check("R10", "parked at zero (down)", int'(count), 0);

    // R11 R12: event strobes under prescaled up-down
    curReq = "R12";
    wrCtrl(2, 1, 0, 1, 2); idle(80);

    finishRun();
  end

endmodule